// File: doc/BRIEF.md
# Two-Port Memory with Same-Address Collision Arbitration

This block is a synchronous two-port word memory whose left and right ports are fully independent: each has an active-low select, a write strobe, an address and write data, and each returns read data one clock later. When both ports are selected on the same word in the same cycle, an arbiter lets one access proceed and raises a busy flag for the other side in that same cycle. A write from the flagged side is gated off before it reaches the array. The arbiter looks only at selects and addresses, never at the write strobes.

A mode input chooses between two roles. With the mode input high, the block arbitrates and drives its busy outputs. With it low, no arbitration takes place and the busy outputs stay low. Instead, a per-side write-permit input gates writes, so that several of these memories can be ganged side by side in width under the busy decisions of one arbitrating copy. Word width and address width are parameters. The default address width is kept narrow so that the default array stays small; 14 bits gives the full-size array.

Top module: `dpram_collide`

## Requirements
- R1: In arbitrating mode (`master_i`=1), when both ports are selected (`*_ce_n`=0) on the same address, exactly one of `l_busy_o` and `r_busy_o` is 1 in that same cycle.
- R2: The write strobes `l_we` and `r_we` have no effect on which side is flagged busy.
- R3: A write from a side whose busy output is 1 is discarded, and the addressed word keeps its previous contents. A write from the unflagged side is stored.
- R4: On a fresh collision, where neither port was selected on that address in the previous cycle, or both were, the left side wins and `r_busy_o`=1.
- R5: A port that was selected on the address in the previous cycle keeps priority over a port that has just arrived there. The newcomer stays flagged for as long as both ports remain selected on that address, and the flag drops once the addresses differ or either port is deselected.
- R6: A deselected port (`*_ce_n`=1) writes nothing, takes no part in arbitration, causes no busy flag, and its read data output holds its last value.
- R7: In pass-through mode (`master_i`=0), both busy outputs are 0. A side's write is discarded while its `*_wok_i` is 0 and stored while it is 1.
- R8: In pass-through mode, if both ports write the same address in the same cycle with permission, the left port's data is stored.
- R9: A selected port's `*_rdata` shows, after the next rising edge, the word stored before that edge's writes. This holds for every selected access, including writes and accesses that lost arbitration.
- R10: While `rst_n`=0 and right after it is released, both busy outputs and both read data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| master_i | input | 1 | 1 = arbitrate and drive busy; 0 = pass-through with write permits |
| l_ce_n | input | 1 | Left port select, active low |
| l_we | input | 1 | Left write strobe (1 = write) |
| l_addr | input | ADDR_W (10) | Left word address |
| l_wdata | input | DATA_W (9) | Left write data |
| l_rdata | output | DATA_W (9) | Left read data, registered |
| l_wok_i | input | 1 | Left write permit in pass-through mode, 0 blocks writes |
| l_busy_o | output | 1 | Left side lost arbitration this cycle |
| r_ce_n | input | 1 | Right port select, active low |
| r_we | input | 1 | Right write strobe (1 = write) |
| r_addr | input | ADDR_W (10) | Right word address |
| r_wdata | input | DATA_W (9) | Right write data |
| r_rdata | output | DATA_W (9) | Right read data, registered |
| r_wok_i | input | 1 | Right write permit in pass-through mode, 0 blocks writes |
| r_busy_o | output | 1 | Right side lost arbitration this cycle |

## Verification
An arbitration decision and a gated write fall in the same cycle: the bench provokes this by driving both ports onto one address, with and without write strobes, and with one port already resident on the address in the cycle before. It judges the outcome by comparing each busy output against a behavioural model before the edge, then reading the word back to confirm whose data survived. A read and a write to the same word also share an edge. The loser's read data is compared with the model's pre-write word, which shows both that read-before-write ordering holds and that the blocked write never landed.

// File: rtl/dpcol_pkg.sv
package dpcol_pkg;
  typedef enum logic {
    SIDE_L = 1'b0,
    SIDE_R = 1'b1
  } side_e;

  localparam int NUM_SIDES = 2;
endpackage

// File: rtl/dpcol_arbiter.sv
module dpcol_arbiter
  import dpcol_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master,
  input  logic              en_l,
  input  logic              en_r,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [ADDR_W-1:0] addr_r,
  output logic              arb_busy_l,
  output logic              arb_busy_r
);
  // state from the previous cycle: who was resident where
  logic              res_en_l_q, res_en_r_q;
  logic [ADDR_W-1:0] res_addr_l_q, res_addr_r_q;
  logic              coll_q;
  side_e             win_q;

  logic  hit, l_res, r_res;
  side_e win_d;

  always_comb begin
    hit   = master && en_l && en_r && (addr_l == addr_r);
    l_res = res_en_l_q && (res_addr_l_q == addr_l);
    r_res = res_en_r_q && (res_addr_r_q == addr_r);
    if (l_res && r_res && coll_q) begin
      win_d = win_q;           // ongoing collision: keep the earlier decision
    end else if (r_res && !l_res) begin
      win_d = SIDE_R;          // right was there first
    end else begin
      win_d = SIDE_L;          // fresh or left resident: left has priority
    end
    arb_busy_l = hit && (win_d == SIDE_R);
    arb_busy_r = hit && (win_d == SIDE_L);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_en_l_q   <= 1'b0;
      res_en_r_q   <= 1'b0;
      res_addr_l_q <= '0;
      res_addr_r_q <= '0;
      coll_q       <= 1'b0;
      win_q        <= SIDE_L;
    end else begin
      res_en_l_q   <= en_l;
      res_en_r_q   <= en_r;
      res_addr_l_q <= addr_l;
      res_addr_r_q <= addr_r;
      coll_q       <= hit;
      if (hit) begin
        win_q <= win_d;
      end
    end
  end
endmodule

// File: rtl/dpcol_wgate.sv
module dpcol_wgate (
  input  logic master,
  input  logic en,
  input  logic we,
  input  logic arb_busy,
  input  logic wok,
  output logic wr_go,
  output logic busy_pin
);
  logic blocked;

  always_comb begin
    blocked  = master ? arb_busy : !wok;
    wr_go    = en && we && !blocked;
    busy_pin = master && arb_busy;
  end
endmodule

// File: rtl/dpcol_array.sv
module dpcol_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_l,
  input  logic              en_r,
  input  logic              wr_l,
  input  logic              wr_r,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic [DATA_W-1:0] wd_l,
  input  logic [DATA_W-1:0] wd_r,
  output logic [DATA_W-1:0] rd_l,
  output logic [DATA_W-1:0] rd_r
);
  logic [DATA_W-1:0] mem [DEPTH];

  // right is applied first so a same-word left write is the one kept
  always_ff @(posedge clk) begin
    if (wr_r) mem[addr_r] <= wd_r;
    if (wr_l) mem[addr_l] <= wd_l;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_l <= '0;
      rd_r <= '0;
    end else begin
      if (en_l) rd_l <= mem[addr_l];
      if (en_r) rd_r <= mem[addr_r];
    end
  end
endmodule

// File: rtl/dpram_collide.sv
module dpram_collide
  import dpcol_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_i,
  input  logic              l_ce_n,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              l_wok_i,
  output logic              l_busy_o,
  input  logic              r_ce_n,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  input  logic              r_wok_i,
  output logic              r_busy_o
);
  logic [NUM_SIDES-1:0] en, we, wok, arb_busy, wr_go, busy_pin;

  assign en       = {~r_ce_n, ~l_ce_n};
  assign we       = {r_we, l_we};
  assign wok      = {r_wok_i, l_wok_i};
  assign l_busy_o = busy_pin[SIDE_L];
  assign r_busy_o = busy_pin[SIDE_R];

  dpcol_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .master    (master_i),
    .en_l      (en[SIDE_L]),
    .en_r      (en[SIDE_R]),
    .addr_l    (l_addr),
    .addr_r    (r_addr),
    .arb_busy_l(arb_busy[SIDE_L]),
    .arb_busy_r(arb_busy[SIDE_R])
  );

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    dpcol_wgate u_gate (
      .master  (master_i),
      .en      (en[s]),
      .we      (we[s]),
      .arb_busy(arb_busy[s]),
      .wok     (wok[s]),
      .wr_go   (wr_go[s]),
      .busy_pin(busy_pin[s])
    );
  end

  dpcol_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .en_l  (en[SIDE_L]),
    .en_r  (en[SIDE_R]),
    .wr_l  (wr_go[SIDE_L]),
    .wr_r  (wr_go[SIDE_R]),
    .addr_l(l_addr),
    .addr_r(r_addr),
    .wd_l  (l_wdata),
    .wd_r  (r_wdata),
    .rd_l  (l_rdata),
    .rd_r  (r_rdata)
  );
endmodule

// File: rtl/dpram_collide_chk.sv
module dpram_collide_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              master_i,
  input logic              l_ce_n,
  input logic              r_ce_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic [ADDR_W-1:0] r_addr,
  input logic              l_wok_i,
  input logic              r_wok_i,
  input logic              l_busy_o,
  input logic              r_busy_o,
  input logic [1:0]        wr_go
);
  logic past_ok;
  logic same;

  always_ff @(posedge clk) past_ok <= rst_n;

  assign same = master_i && !l_ce_n && !r_ce_n && (l_addr == r_addr);

  assert_one_loser_R1: assert property (@(posedge clk) disable iff (!rst_n)
    same |-> ($countones({l_busy_o, r_busy_o}) == 1));

  assert_busy_needs_collision_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (l_ce_n || r_ce_n) |-> (!l_busy_o && !r_busy_o));

  assert_left_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    l_busy_o |-> !wr_go[0]);

  assert_right_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    r_busy_o |-> !wr_go[1]);

  assert_quiet_slave_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !master_i |-> (!l_busy_o && !r_busy_o));

  assert_permit_left_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_i && !l_wok_i) |-> !wr_go[0]);

  assert_permit_right_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_i && !r_wok_i) |-> !wr_go[1]);

  assert_fresh_left_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && same && $past(l_ce_n) && $past(r_ce_n)) |-> r_busy_o);

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && same && $past(same) && $stable(l_addr) && $stable(r_addr))
      |-> ($stable(l_busy_o) && $stable(r_busy_o)));
endmodule

bind dpram_collide dpram_collide_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .master_i(master_i),
  .l_ce_n  (l_ce_n),
  .r_ce_n  (r_ce_n),
  .l_addr  (l_addr),
  .r_addr  (r_addr),
  .l_wok_i (l_wok_i),
  .r_wok_i (r_wok_i),
  .l_busy_o(l_busy_o),
  .r_busy_o(r_busy_o),
  .wr_go   (wr_go)
);

// File: tb/dpram_collide_tb.sv
module dpram_collide_tb;
  localparam int AW = 10;
  localparam int DW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          master_i = 1'b1;
  logic          l_ce_n = 1'b1, r_ce_n = 1'b1;
  logic          l_we = 1'b0, r_we = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic          l_wok_i = 1'b1, r_wok_i = 1'b1;
  logic [DW-1:0] l_rdata, r_rdata;
  logic          l_busy_o, r_busy_o;

  always #4 clk = ~clk;

  dpram_collide #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .master_i(master_i),
    .l_ce_n(l_ce_n), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_wok_i(l_wok_i), .l_busy_o(l_busy_o),
    .r_ce_n(r_ce_n), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_wok_i(r_wok_i), .r_busy_o(r_busy_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int mem [int];
  bit p_len = 0, p_ren = 0, p_coll = 0;
  int p_la = 0, p_ra = 0;
  int p_win = 0;                 // 0 = left, 1 = right
  int exp_rl = 0, exp_rr = 0;
  bit kn_rl = 1, kn_rr = 1;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit m,
                      input bit lce, input bit lwe, input int la, input int lwd,
                      input bit rce, input bit rwe, input int ra, input int rwd,
                      input bit lok, input bit rok, input string tag);
    bit hit, lh, rh, eb_l, eb_r, go_l, go_r;
    int w;
    master_i = m;
    l_ce_n = lce; l_we = lwe; l_addr = la[AW-1:0]; l_wdata = lwd[DW-1:0];
    r_ce_n = rce; r_we = rwe; r_addr = ra[AW-1:0]; r_wdata = rwd[DW-1:0];
    l_wok_i = lok; r_wok_i = rok;
    #2;
    hit = m && !lce && !rce && (la == ra);
    lh = p_len && (p_la == la);
    rh = p_ren && (p_ra == ra);
    if (lh && rh && p_coll) w = p_win;
    else if (rh && !lh) w = 1;
    else w = 0;
    eb_l = hit && (w == 1);
    eb_r = hit && (w == 0);
    check(tag, "l_busy_o", int'(l_busy_o), int'(eb_l));
    check(tag, "r_busy_o", int'(r_busy_o), int'(eb_r));
    go_l = !lce && lwe && (m ? !eb_l : lok);
    go_r = !rce && rwe && (m ? !eb_r : rok);
    if (!lce) begin
      kn_rl = mem.exists(la);
      exp_rl = kn_rl ? mem[la] : 0;
    end
    if (!rce) begin
      kn_rr = mem.exists(ra);
      exp_rr = kn_rr ? mem[ra] : 0;
    end
    @(posedge clk);
    if (go_r) mem[ra] = rwd;
    if (go_l) mem[la] = lwd;
    p_len = !lce; p_la = la;
    p_ren = !rce; p_ra = ra;
    p_coll = hit;
    if (hit) p_win = w;
    @(negedge clk);
    if (kn_rl) check(tag, "l_rdata", int'(l_rdata), exp_rl);
    if (kn_rr) check(tag, "r_rdata", int'(r_rdata), exp_rr);
  endtask

  task automatic idle(input string tag);
    step(1, 1, 0, 0, 0, 1, 0, 0, 0, 1, 1, tag);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10", "l_busy_o in reset", int'(l_busy_o), 0);
    check("R10", "l_rdata in reset", int'(l_rdata), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R10", "r_busy_o after reset", int'(r_busy_o), 0);
    check("R10", "r_rdata after reset", int'(r_rdata), 0);

    // R6: single-port writes, the other port deselected
    step(1, 0, 1, 5, 'h1A5, 1, 0, 0, 0, 1, 1, "R6");
    step(1, 1, 0, 0, 0, 0, 1, 7, 'h0C3, 1, 1, "R6");
    step(1, 0, 1, 20, 'h099, 1, 0, 0, 0, 1, 1, "R6");
    // R9: independent reads return the stored words one clock later
    step(1, 0, 0, 5, 0, 0, 0, 7, 0, 1, 1, "R9");
    idle("R6");   // rdata holds while deselected

    // R4 and R3: fresh collision, both writing; left wins
    step(1, 0, 1, 9, 'h111, 0, 1, 9, 'h0EE, 1, 1, "R4");
    idle("R3");
    // R2: left reads, right writes; still left wins, right write blocked
    step(1, 0, 0, 9, 0, 0, 1, 9, 'h055, 1, 1, "R2");
    // R9: losing read still returns data (previous step's check), and
    // R3: the word still holds the left data
    step(1, 0, 0, 9, 0, 1, 0, 0, 0, 1, 1, "R3");
    idle("R6");

    // R5: right resident on 20, left arrives writing and is flagged
    step(1, 1, 0, 0, 0, 0, 0, 20, 0, 1, 1, "R5");
    step(1, 0, 1, 20, 'h1FF, 0, 0, 20, 0, 1, 1, "R5");
    step(1, 0, 1, 20, 'h1EE, 0, 0, 20, 0, 1, 1, "R5");
    step(1, 0, 0, 21, 0, 0, 0, 20, 0, 1, 1, "R5");
    // R5: left resident on 30, right arrives and is flagged
    step(1, 0, 1, 30, 'h033, 1, 0, 0, 0, 1, 1, "R5");
    step(1, 0, 0, 30, 0, 0, 1, 30, 'h0F0, 1, 1, "R5");
    step(1, 0, 0, 30, 0, 1, 0, 0, 0, 1, 1, "R5");
    // R6: same address but right deselected: no busy, left write lands
    step(1, 0, 1, 20, 'h0AA, 1, 1, 20, 'h0BB, 1, 1, "R6");
    step(1, 1, 0, 0, 0, 0, 0, 20, 0, 1, 1, "R6");

    // R8: pass-through, both write one word; left data kept, no busy
    step(0, 0, 1, 40, 'h123, 0, 1, 40, 'h045, 1, 1, "R8");
    step(0, 0, 0, 40, 0, 0, 0, 40, 0, 1, 1, "R8");
    // R7: write permits
    step(0, 0, 1, 41, 'h066, 1, 0, 0, 0, 1, 1, "R7");
    step(0, 0, 1, 41, 'h077, 1, 0, 0, 0, 0, 1, "R7");
    step(0, 1, 0, 0, 0, 0, 1, 41, 'h0DD, 1, 0, "R7");
    step(0, 0, 0, 41, 0, 1, 0, 0, 0, 1, 1, "R7");
    step(0, 1, 0, 0, 0, 0, 1, 41, 'h0DD, 1, 1, "R7");
    step(0, 0, 0, 41, 0, 0, 0, 41, 0, 1, 1, "R7");
    // R1: back to arbitration, collision on 41 with reads only
    step(1, 0, 0, 41, 0, 0, 0, 41, 0, 1, 1, "R1");
    idle("R1");

    done = 1;
    summary();
    $finish;
  end
endmodule